// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

This block holds a 64-entry table of conversion command words and walks through it for two queues that share the table. Queue 1 starts at entry 0 and runs upward until it reaches a programmable boundary index. Queue 2 starts at that boundary and runs up to entry 63. Each fetched command goes to an external converter through a start/done handshake, and only one command is outstanding at a time.

The block keeps one shared current-command pointer, which moves when a command is issued. It also keeps a last-executed pointer for each queue, which moves only when a conversion result for that queue is written back. The two kinds of pointer can therefore differ while a conversion is in flight, and after queue 1 ends at the boundary. Both last-executed pointers are read out through one 16-bit status word.

A stop-mode input returns the block to its idle state. A debug-mode input holds off new fetches without disturbing the pointers.

Top module: `dual_queue_cmd_seq`

## Requirements
- R1: The table has 64 entries of 10 bits, written through `tbl_we`/`tbl_addr`/`tbl_data`. Bit 9 is the pause flag, bits 8:6 are the sample time and bits 5:0 are the channel. An issued command presents that entry's channel on `conv_chan` and its sample time on `conv_stime`.
- R2: A queue's last-executed pointer takes the table index of a completed command in the cycle its result is written (`conv_done` while a command is outstanding). It does not change when the command is fetched.
- R3: Each last-executed pointer shows the last completed command of its own queue only. It is left unchanged by results of the other queue, whichever queue is active.
- R4: Queue 1 runs from index 0 upward. Fetching an index greater than or equal to `q2_base` ends queue 1 without issuing that command. `cur_ptr` then shows `q2_base`, and the queue-1 pointer keeps the last queue-1 command.
- R5: Queue 2 runs from `q2_base` up to index 63 and then goes idle. `cur_ptr` keeps 63.
- R6: Queue 1 has priority. A queue-2 command is issued only while queue 1 is neither running nor waiting on an issued command.
- R7: After the result of a command with the pause flag set, its queue pauses. A trigger on a paused queue resumes it at the next entry. A trigger on an idle queue starts it from its first entry.
- R8: While `stop_mode` is high, nothing is issued. Both queues go idle, any outstanding command is dropped, `cur_ptr` clears to 0, and both last-executed pointers become 63 (status 0x3F3F).
- R9: While `debug_mode` is high, no command is fetched or issued and both last-executed pointers keep their values. Fetching resumes when the input falls.
- R10: `status_word` bits 13:8 hold the queue-1 pointer and bits 5:0 hold the queue-2 pointer. Bits 15:14 and 7:6 read as 0. The value after reset is 0x3F3F.
- R11: `conv_start` is a one-cycle pulse, and `cur_ptr` shows the issued index from that same cycle. No new start occurs until `conv_done` returns. A `conv_done` with nothing outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_mode | input | 1 | Stop mode: idles the queues and sets both pointers to 63 |
| debug_mode | input | 1 | Debug mode: holds off fetching |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table write index |
| tbl_data | input | 10 | Command word to write |
| q2_base | input | 6 | First table index of queue 2 |
| trig_q1 | input | 1 | Start or resume queue 1 |
| trig_q2 | input | 1 | Start or resume queue 2 |
| conv_done | input | 1 | Converter result write for the outstanding command |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 6 | Channel of the issued command |
| conv_stime | output | 3 | Sample time of the issued command |
| cur_ptr | output | 6 | Shared current-command pointer |
| status_word | output | 16 | Last-executed pointers of both queues |

## Verification
The scoreboard checks that the status word keeps its old value in the cycle a command starts and moves only after its result. A design that updated on fetch would show the new index one conversion too early. Queue 1 is run into the boundary, where a wrong design would issue the boundary entry or copy the boundary into the queue-1 pointer instead of leaving it only on the current pointer. Both queues are triggered in the same cycle to show queue-1 commands leaving first. A paused queue 2 is run around queue-1 traffic to catch one queue's results landing in the other's pointer. Stop and debug are applied with a queue paused, along with a stray done pulse: a wrong design would keep stale pointers, resume instead of restart after stop, or issue while debug is high.

// File: rtl/dqs_pkg.sv
package dqs_pkg;
    localparam int PTR_W   = 6;
    localparam int DEPTH   = 1 << PTR_W;
    localparam int CHAN_W  = 6;
    localparam int STIME_W = 3;
    localparam int WORD_W  = 1 + STIME_W + CHAN_W;
    localparam int BYTE_W  = 8;
    localparam int STAT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {Q_IDLE, Q_RUN, Q_HOLD} qstate_t;

    typedef struct packed {
        logic               pause;
        logic [STIME_W-1:0] stime;
        logic [CHAN_W-1:0]  chan;
    } cmd_t;

    typedef struct packed {
        logic             q2;
        logic [PTR_W-1:0] idx;
        logic             pause;
    } tag_t;

    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
        return cmd_t'(w);
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input logic [PTR_W-1:0] p1,
                                                      input logic [PTR_W-1:0] p2);
        return {{(BYTE_W-PTR_W){1'b0}}, p1, {(BYTE_W-PTR_W){1'b0}}, p2};
    endfunction
endpackage

// File: rtl/dqs_cmd_table.sv
module dqs_cmd_table
    import dqs_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dqs_sequencer.sv
module dqs_sequencer
    import dqs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_mode,
    input  logic               debug_mode,
    input  logic               trig_q1,
    input  logic               trig_q2,
    input  logic [PTR_W-1:0]   q2_base,
    input  logic               conv_done,
    input  cmd_t               rd_cmd,
    output logic [PTR_W-1:0]   rd_addr,
    output logic               conv_start,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic [STIME_W-1:0] conv_stime,
    output logic [PTR_W-1:0]   cur_ptr,
    output logic               wb_valid,
    output logic               wb_q2,
    output logic [PTR_W-1:0]   wb_idx
);
    qstate_t          st  [2];
    logic [PTR_W:0]   nxt [2];
    logic             busy;
    tag_t             tag;

    logic             sel1, sel2, can_go, q1_end, q2_end, issue;
    logic [PTR_W:0]   fetch_idx;
    logic [1:0]       trig;

    always_comb begin
        trig      = {trig_q2, trig_q1};
        sel1      = (st[0] == Q_RUN);
        sel2      = !sel1 && (st[1] == Q_RUN);
        can_go    = !busy && !debug_mode && !stop_mode;
        fetch_idx = sel1 ? nxt[0] : nxt[1];
        q1_end    = sel1 && (nxt[0] >= {1'b0, q2_base});
        q2_end    = sel2 && nxt[1][PTR_W];
        issue     = can_go && ((sel1 && !q1_end) || (sel2 && !q2_end));
        rd_addr   = fetch_idx[PTR_W-1:0];
        wb_valid  = busy && conv_done;
        wb_q2     = tag.q2;
        wb_idx    = tag.idx;
    end

    always_ff @(posedge clk) begin
        if (rst || stop_mode) begin
            for (int q = 0; q < 2; q++) begin
                st[q]  <= Q_IDLE;
                nxt[q] <= '0;
            end
            busy       <= 1'b0;
            tag        <= '0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
            conv_stime <= '0;
            cur_ptr    <= '0;
        end else begin
            conv_start <= issue;
            for (int q = 0; q < 2; q++) begin
                if (trig[q] && st[q] != Q_RUN) begin
                    st[q] <= Q_RUN;
                    if (st[q] == Q_IDLE)
                        nxt[q] <= (q == 0) ? '0 : {1'b0, q2_base};
                end
            end
            if (can_go && q1_end) begin
                st[0]   <= Q_IDLE;
                cur_ptr <= q2_base;
            end
            if (can_go && q2_end)
                st[1] <= Q_IDLE;
            if (issue) begin
                busy       <= 1'b1;
                cur_ptr    <= rd_addr;
                conv_chan  <= rd_cmd.chan;
                conv_stime <= rd_cmd.stime;
                tag        <= '{q2: !sel1, idx: rd_addr, pause: rd_cmd.pause};
                if (sel1) nxt[0] <= fetch_idx + 1'b1;
                else      nxt[1] <= fetch_idx + 1'b1;
            end
            if (wb_valid) begin
                busy <= 1'b0;
                if (tag.pause) st[tag.q2] <= Q_HOLD;
            end
        end
    end

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> !conv_start);
    assert_no_issue_debug_R9: assert property (@(posedge clk) disable iff (rst)
        debug_mode |=> !conv_start);
    assert_no_issue_stop_R8: assert property (@(posedge clk) disable iff (rst)
        stop_mode |=> !conv_start);
    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);
endmodule

// File: rtl/dqs_last_ptr.sv
module dqs_last_ptr
    import dqs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_mode,
    input  logic              wb_valid,
    input  logic              wb_q2,
    input  logic [PTR_W-1:0]  wb_idx,
    output logic [STAT_W-1:0] status_word
);
    logic [PTR_W-1:0] last1, last2;

    always_ff @(posedge clk) begin
        if (rst || stop_mode) begin
            last1 <= '1;
            last2 <= '1;
        end else if (wb_valid) begin
            if (wb_q2) last2 <= wb_idx;
            else       last1 <= wb_idx;
        end
    end

    assign status_word = pack_status(last1, last2);

    assert_hold_without_result_R2: assert property (@(posedge clk) disable iff (rst)
        (!wb_valid && !stop_mode) |=> ($stable(last1) && $stable(last2)));
    assert_stop_sets_max_R8: assert property (@(posedge clk) disable iff (rst)
        stop_mode |=> (last1 == '1 && last2 == '1));
    assert_other_queue_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_q2 && !stop_mode) |=> $stable(last1));
endmodule

// File: rtl/dual_queue_cmd_seq.sv
module dual_queue_cmd_seq
    import dqs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_mode,
    input  logic               debug_mode,
    input  logic               tbl_we,
    input  logic [PTR_W-1:0]   tbl_addr,
    input  logic [WORD_W-1:0]  tbl_data,
    input  logic [PTR_W-1:0]   q2_base,
    input  logic               trig_q1,
    input  logic               trig_q2,
    input  logic               conv_done,
    output logic               conv_start,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic [STIME_W-1:0] conv_stime,
    output logic [PTR_W-1:0]   cur_ptr,
    output logic [STAT_W-1:0]  status_word
);
    logic [PTR_W-1:0]  rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              wb_valid, wb_q2;
    logic [PTR_W-1:0]  wb_idx;

    dqs_cmd_table u_table (
        .clk     (clk),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    dqs_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .stop_mode  (stop_mode),
        .debug_mode (debug_mode),
        .trig_q1    (trig_q1),
        .trig_q2    (trig_q2),
        .q2_base    (q2_base),
        .conv_done  (conv_done),
        .rd_cmd     (decode_word(rd_word)),
        .rd_addr    (rd_addr),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .conv_stime (conv_stime),
        .cur_ptr    (cur_ptr),
        .wb_valid   (wb_valid),
        .wb_q2      (wb_q2),
        .wb_idx     (wb_idx)
    );

    dqs_last_ptr u_ptr (
        .clk         (clk),
        .rst         (rst),
        .stop_mode   (stop_mode),
        .wb_valid    (wb_valid),
        .wb_q2       (wb_q2),
        .wb_idx      (wb_idx),
        .status_word (status_word)
    );
endmodule

// File: tb/dual_queue_cmd_seq_test.sv
module dual_queue_cmd_seq_test;
    localparam int LAT = 3;

    logic        clk = 0;
    logic        rst = 1;
    logic        stop_mode = 0, debug_mode = 0;
    logic        tbl_we = 0;
    logic [5:0]  tbl_addr = 0;
    logic [9:0]  tbl_data = 0;
    logic [5:0]  q2_base = 0;
    logic        trig_q1 = 0, trig_q2 = 0;
    logic        conv_done = 0;
    logic        conv_start;
    logic [5:0]  conv_chan;
    logic [2:0]  conv_stime;
    logic [5:0]  cur_ptr;
    logic [15:0] status_word;

    dual_queue_cmd_seq uut (.*);

    always #5 clk = ~clk;

    typedef struct { bit q2; int idx; } item_t;
    item_t exp_q[$];
    int checks = 0, errors = 0;
    int exp_p1 = 63, exp_p2 = 63;
    int pend = 0, n_start = 0;
    bit chk_after = 0, force_done = 0, done_flag = 0;
    item_t cur_it;

    function automatic int chan_of(int i); return (i * 5 + 1) % 64; endfunction
    function automatic int stime_of(int i); return i % 8; endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put_cmd(int i, bit p);
        @(negedge clk);
        tbl_we = 1; tbl_addr = 6'(i);
        tbl_data = {p, 3'(stime_of(i)), 6'(chan_of(i))};
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic push(bit q2, int lo, int hi);
        for (int i = lo; i <= hi; i++) exp_q.push_back('{q2: q2, idx: i});
    endtask

    task automatic pulse(bit t1, bit t2);
        @(negedge clk);
        trig_q1 = t1; trig_q2 = t2;
        @(negedge clk);
        trig_q1 = 0; trig_q2 = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || pend != 0 || chk_after) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // converter model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 0;
            if (chk_after) begin
                chk(int'(status_word[13:8]) == exp_p1, "R2 q1 pointer after result", int'(status_word[13:8]), exp_p1);
                chk(int'(status_word[5:0]) == exp_p2, "R3 q2 pointer after result", int'(status_word[5:0]), exp_p2);
                chk_after = 0;
            end
            if (force_done) begin
                conv_done = 1; force_done = 0; done_flag = 1;
            end else if (pend > 0) begin
                if (conv_start) chk(0, "R11 start while outstanding", 1, 0);
                pend--;
                if (pend == 0) begin
                    conv_done = 1;
                    if (cur_it.q2) exp_p2 = cur_it.idx; else exp_p1 = cur_it.idx;
                    chk_after = 1;
                end
            end else if (conv_start) begin
                n_start++;
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected start, cur_ptr", int'(cur_ptr), -1);
                end else begin
                    cur_it = exp_q.pop_front();
                    chk(int'(cur_ptr) == cur_it.idx, "R11 cur_ptr at start", int'(cur_ptr), cur_it.idx);
                    chk(int'(conv_chan) == chan_of(cur_it.idx), "R1 channel", int'(conv_chan), chan_of(cur_it.idx));
                    chk(int'(conv_stime) == stime_of(cur_it.idx), "R1 sample time", int'(conv_stime), stime_of(cur_it.idx));
                    if (cur_it.q2)
                        chk(int'(status_word[5:0]) == exp_p2, "R2 no update on fetch q2", int'(status_word[5:0]), exp_p2);
                    else
                        chk(int'(status_word[13:8]) == exp_p1, "R2 no update on fetch q1", int'(status_word[13:8]), exp_p1);
                    pend = LAT;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(status_word == 16'h3F3F, "R10 reset status", int'(status_word), 16'h3F3F);
        chk(conv_start == 0, "R11 no start after reset", int'(conv_start), 0);
        chk(cur_ptr == 0, "R8 cur_ptr reset", int'(cur_ptr), 0);

        for (int i = 0; i < 64; i++) put_cmd(i, i == 6);
        q2_base = 4;

        // R4: queue 1 ends at the boundary
        push(0, 0, 3);
        pulse(1, 0);
        drain();
        chk(cur_ptr == 4, "R4 cur_ptr holds boundary", int'(cur_ptr), 4);
        chk(status_word[13:8] == 3, "R4 q1 pointer keeps last q1", int'(status_word[13:8]), 3);
        chk(status_word[5:0] == 63, "R3 q2 pointer untouched", int'(status_word[5:0]), 63);

        // R7: queue 2 pauses at entry 6
        push(1, 4, 6);
        pulse(0, 1);
        drain();
        s0 = n_start;
        repeat (10) @(negedge clk);
        chk(n_start == s0, "R7 paused queue issues nothing", n_start, s0);
        chk(status_word == 16'h0306, "R10 status layout", int'(status_word), 16'h0306);

        // R3: queue 1 runs while queue 2 paused
        push(0, 0, 3);
        pulse(1, 0);
        drain();
        chk(status_word[5:0] == 6, "R3 q2 pointer kept across q1 run", int'(status_word[5:0]), 6);

        // R7 resume, R5 run to the end
        push(1, 7, 63);
        pulse(0, 1);
        drain();
        chk(cur_ptr == 63, "R5 cur_ptr at table end", int'(cur_ptr), 63);
        chk(status_word[5:0] == 63, "R5 q2 pointer at end", int'(status_word[5:0]), 63);
        s0 = n_start;
        repeat (10) @(negedge clk);
        chk(n_start == s0, "R5 queue 2 idle after end", n_start, s0);

        // R6: both triggered together, queue 1 first; R7 idle restart
        q2_base = 2;
        push(0, 0, 1);
        push(1, 2, 6);
        pulse(1, 1);
        drain();
        chk(status_word == 16'h0106, "R6 pointers after priority run", int'(status_word), 16'h0106);

        // R9: debug holds off fetch
        debug_mode = 1;
        push(0, 0, 1);
        pulse(1, 0);
        s0 = n_start;
        repeat (15) @(negedge clk);
        chk(n_start == s0, "R9 no start in debug", n_start, s0);
        chk(status_word == 16'h0106, "R9 pointers unchanged in debug", int'(status_word), 16'h0106);
        debug_mode = 0;
        drain();
        chk(status_word[13:8] == 1, "R9 resumes after debug", int'(status_word[13:8]), 1);

        // R11: stray done ignored
        force_done = 1;
        while (!done_flag) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(status_word == 16'h0106, "R11 stray done ignored", int'(status_word), 16'h0106);

        // R8: stop mode with queue 2 paused
        @(negedge clk);
        stop_mode = 1; trig_q2 = 1;
        s0 = n_start;
        repeat (3) @(negedge clk);
        trig_q2 = 0; stop_mode = 0;
        chk(status_word == 16'h3F3F, "R8 stop resets status", int'(status_word), 16'h3F3F);
        chk(cur_ptr == 0, "R8 stop clears cur_ptr", int'(cur_ptr), 0);
        repeat (5) @(negedge clk);
        chk(n_start == s0, "R8 nothing issued around stop", n_start, s0);
        exp_p1 = 63; exp_p2 = 63;
        push(1, 2, 6);
        pulse(0, 1);
        drain();
        chk(status_word == 16'h3F06, "R8 queue restarts from base after stop", int'(status_word), 16'h3F06);

        // R4: boundary at 0 ends queue 1 at once
        q2_base = 0;
        pulse(1, 0);
        repeat (5) @(negedge clk);
        chk(cur_ptr == 0, "R4 zero boundary cur_ptr", int'(cur_ptr), 0);
        chk(status_word[13:8] == 63, "R4 zero boundary q1 pointer", int'(status_word[13:8]), 63);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule